// File: doc/BRIEF.md
# Shift-then-saturate execution unit

This unit executes the signed and unsigned saturate instructions of a 32-bit integer datapath, and it is purely combinational. It decodes the instruction word to get the register indices, the shift control and the saturation width. It first shifts the operand value that the register file supplies, then clamps that shifted value to an n-bit signed or unsigned range.

The result goes out together with a write-enable and the destination index. The sticky saturation status bit comes in, and a version of it that has been ORed with this instruction's clamp event goes back out. The condition check itself is done elsewhere. This unit receives only a condition-pass bit, and it uses that bit unless the condition field of the instruction is "always".

Top module: `sat_exec`

## Requirements
- R1: The instruction fields are decoded as follows. Source index `rn_idx_o` comes from bits 3:0. Destination index `rd_idx_o` comes from bits 15:12. Shift amount comes from bits 11:7 and shift type from bit 6. Saturation width n comes from bits 20:16, and the condition from bits 31:28.
- R2: With shift type 0, the operand is shifted left logically by the shift amount before clamping. Bits shifted out are lost.
- R3: With shift type 1, the operand is shifted right arithmetically by the shift amount. An amount of 0 means a shift of 31, which leaves every bit a copy of the sign bit.
- R4: When `sign_mode_i`=1, the clamp is signed. A shifted value v, read as a signed 32-bit number, that is above 2^n−1 gives 2^n−1. A value below −2^n gives −2^n, whose bit pattern is ~(2^n−1). Any other value passes through unchanged.
- R5: When `sign_mode_i`=0, the clamp is unsigned. A negative shifted value gives 0. A value above 2^n−1 gives 2^n−1. Any other value passes through unchanged.
- R6: `sticky_o` is `sticky_i` ORed with "an executing instruction clamped". The unit never clears the sticky bit.
- R7: The instruction executes when the condition field is 4'hE or when `cond_pass_i`=1. When it does not execute, `wr_en_o`=0 and `sticky_o` equals `sticky_i`. When it executes, `wr_en_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| sign_mode_i | input | 1 | 1 = signed clamp, 0 = unsigned clamp |
| cond_pass_i | input | 1 | External condition evaluation passed |
| sticky_i | input | 1 | Current sticky saturation flag |
| rn_val_i | input | 32 | Source operand value |
| rn_idx_o | output | 4 | Source register index |
| rd_idx_o | output | 4 | Destination register index |
| result_o | output | 32 | Shifted and clamped result |
| wr_en_o | output | 1 | Destination write-enable |
| sticky_o | output | 1 | Updated sticky saturation flag |

## Verification
Directed operands sit just inside and just outside each clamp bound. These separate an off-by-one bound from a correct one, and a complemented bound from a negated one. The most-negative and most-positive words, and the saturation width 0, test the edges of the range arithmetic. An arithmetic right shift with amount 0 tells the full-width-shift rule apart from a plain shift by zero. A sweep covers every saturation width, both shift types and both clamp modes, using mixed operands, and checks each result against a model written in wide signed arithmetic.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned FLD_W   = 5;
  localparam logic [3:0]  COND_ALWAYS = 4'hE;

  typedef struct packed {
    logic [3:0]       cond;
    logic [FLD_W-1:0] sat_n;
    logic [IDX_W-1:0] rd;
    logic [FLD_W-1:0] amt;
    logic             asr;
    logic [IDX_W-1:0] rn;
  } sat_fields_t;
endpackage

// File: rtl/sat_decode.sv
module sat_decode
  import sat_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output sat_fields_t        fld_o
);
  logic unused_bits;
  assign unused_bits = ^{instr_i[27:21], instr_i[5:4]};

  always_comb begin
    fld_o.cond  = instr_i[31:28];
    fld_o.sat_n = instr_i[20:16];
    fld_o.rd    = instr_i[15:12];
    fld_o.amt   = instr_i[11:7];
    fld_o.asr   = instr_i[6];
    fld_o.rn    = instr_i[3:0];
  end
endmodule

// File: rtl/sat_shift.sv
module sat_shift #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              asr_i,
  output logic [DATA_W-1:0] val_o
);
  logic [AMT_W-1:0] eff_amt;

  // amount 0 with arithmetic type encodes a full-width shift
  assign eff_amt = (asr_i && amt_i == '0) ? AMT_W'(DATA_W-1) : amt_i;
  assign val_o = asr_i ? DATA_W'($signed(val_i) >>> eff_amt) : (val_i << eff_amt);

  always_comb begin
    // R3
    asr_sign_chk: assert (!asr_i || val_o[DATA_W-1] == val_i[DATA_W-1]);
    // R2
    lsl_low_zero_chk: assert (asr_i || (val_o & ~({DATA_W{1'b1}} << amt_i)) == '0);
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int unsigned DATA_W = 32,
  parameter bit          SIGNED = 1'b1,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [AMT_W-1:0]  n_i,
  output logic [DATA_W-1:0] val_o,
  output logic              sat_o
);
  logic [DATA_W-1:0] max_v;
  assign max_v = ~({DATA_W{1'b1}} << n_i);

  if (SIGNED) begin : g_signed
    logic [DATA_W-1:0] top;
    logic hi, lo;
    assign top = DATA_W'($signed(val_i) >>> n_i);
    assign hi  = !top[DATA_W-1] && (|top);
    assign lo  = top[DATA_W-1] && !(&top);
    assign val_o = hi ? max_v : (lo ? ~max_v : val_i);
    assign sat_o = hi || lo;

    logic [DATA_W-1:0] res_top;
    assign res_top = DATA_W'($signed(val_o) >>> n_i);
    always_comb begin
      // R4
      signed_range_chk: assert (res_top == '0 || res_top == '1);
      // R4
      signed_pass_chk: assert (sat_o || val_o == val_i);
    end
  end else begin : g_unsigned
    logic neg, over;
    assign neg  = val_i[DATA_W-1];
    assign over = !neg && (val_i > max_v);
    assign val_o = neg ? '0 : (over ? max_v : val_i);
    assign sat_o = neg || over;

    always_comb begin
      // R5
      unsigned_range_chk: assert ((val_o & ~max_v) == '0);
      // R5
      unsigned_pass_chk: assert (sat_o || val_o == val_i);
    end
  end
endmodule

// File: rtl/sat_exec.sv
module sat_exec
  import sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               sign_mode_i,
  input  logic               cond_pass_i,
  input  logic               sticky_i,
  input  logic [DATA_W-1:0]  rn_val_i,
  output logic [IDX_W-1:0]   rn_idx_o,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               wr_en_o,
  output logic               sticky_o
);
  sat_fields_t       fld;
  logic [DATA_W-1:0] shifted, s_res, u_res;
  logic              s_sat, u_sat, sat, exec;

  sat_decode u_dec (.instr_i(instr_i), .fld_o(fld));

  sat_shift #(.DATA_W(DATA_W)) u_shift (
    .val_i(rn_val_i), .amt_i(AMT_W'(fld.amt)), .asr_i(fld.asr), .val_o(shifted)
  );

  sat_clamp #(.DATA_W(DATA_W), .SIGNED(1'b1)) u_sclamp (
    .val_i(shifted), .n_i(AMT_W'(fld.sat_n)), .val_o(s_res), .sat_o(s_sat)
  );

  sat_clamp #(.DATA_W(DATA_W), .SIGNED(1'b0)) u_uclamp (
    .val_i(shifted), .n_i(AMT_W'(fld.sat_n)), .val_o(u_res), .sat_o(u_sat)
  );

  assign exec     = (fld.cond == COND_ALWAYS) || cond_pass_i;
  assign sat      = sign_mode_i ? s_sat : u_sat;
  assign result_o = sign_mode_i ? s_res : u_res;
  assign wr_en_o  = exec;
  assign sticky_o = sticky_i | (exec & sat);
  assign rn_idx_o = fld.rn;
  assign rd_idx_o = fld.rd;

  always_comb begin
    // R6
    sticky_keep_chk: assert (!sticky_i || sticky_o);
    // R7
    no_exec_chk: assert (exec || (!wr_en_o && sticky_o == sticky_i));
  end
endmodule

// File: tb/sat_exec_test.sv
module sat_exec_test;
  logic        clk = 1'b0;
  logic [31:0] instr_i = '0;
  logic        sign_mode_i = 1'b0, cond_pass_i = 1'b0, sticky_i = 1'b0;
  logic [31:0] rn_val_i = '0;
  logic [3:0]  rn_idx_o, rd_idx_o;
  logic [31:0] result_o;
  logic        wr_en_o, sticky_o;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sat_exec uut (.*);

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [4:0] n,
      input logic [3:0] rd, input logic [4:0] amt, input logic t, input logic [3:0] rn);
    return {c, 7'd0, n, rd, amt, t, 2'd0, rn};
  endfunction

  // model: returns {clamped, value}
  function automatic logic [32:0] model(input logic [31:0] v, input logic [4:0] amt,
      input logic t, input logic [4:0] n, input logic sgn);
    longint sv, hi, lo;
    logic [31:0] sh;
    int a;
    if (!t) sh = v << amt;
    else begin
      a = (amt == 0) ? 31 : int'(amt);
      sh = 32'($signed(v) >>> a);
    end
    sv = longint'($signed(sh));
    hi = (64'sd1 <<< n) - 1;
    lo = sgn ? -(64'sd1 <<< n) : 64'sd0;
    if (sv > hi) return {1'b1, 32'(hi)};
    if (sv < lo) return {1'b1, 32'(lo)};
    return {1'b0, sh};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] v, input logic sgn,
      input logic cp, input logic st);
    @(posedge clk);
    instr_i = ins; rn_val_i = v; sign_mode_i = sgn; cond_pass_i = cp; sticky_i = st;
    @(negedge clk);
  endtask

  task automatic t_idle;
    apply(32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R7 idle wr_en", {31'd0, wr_en_o}, 32'd0);
    chk("R7 idle sticky", {31'd0, sticky_o}, 32'd0);
  endtask

  task automatic t_decode;
    apply(mk(4'hE, 5'd31, 4'hA, 5'd0, 1'b0, 4'h5), 32'h1234, 1'b1, 1'b0, 1'b0);
    chk("R1 rd", {28'd0, rd_idx_o}, 32'hA);
    chk("R1 rn", {28'd0, rn_idx_o}, 32'h5);
    chk("R1 result", result_o, 32'h1234);
  endtask

  task automatic t_lsl;
    apply(mk(4'hE, 5'd31, 4'h1, 5'd4, 1'b0, 4'h2), 32'h0000_0123, 1'b1, 1'b0, 1'b0);
    chk("R2 lsl 4", result_o, 32'h0000_1230);
    apply(mk(4'hE, 5'd31, 4'h1, 5'd31, 1'b0, 4'h2), 32'h0000_0003, 1'b1, 1'b0, 1'b0);
    chk("R2 lsl 31 bits lost", result_o, 32'h8000_0000);
  endtask

  task automatic t_asr;
    apply(mk(4'hE, 5'd31, 4'h1, 5'd0, 1'b1, 4'h2), 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    chk("R3 asr0 neg", result_o, 32'hFFFF_FFFF);
    apply(mk(4'hE, 5'd31, 4'h1, 5'd0, 1'b1, 4'h2), 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
    chk("R3 asr0 pos", result_o, 32'h0);
    apply(mk(4'hE, 5'd31, 4'h1, 5'd4, 1'b1, 4'h2), 32'hF000_0100, 1'b1, 1'b0, 1'b0);
    chk("R3 asr4", result_o, 32'hFF00_0010);
  endtask

  task automatic t_signed;
    apply(mk(4'hE, 5'd7, 4'h1, 5'd0, 1'b0, 4'h2), 32'd1000, 1'b1, 1'b0, 1'b0);
    chk("R4 high", result_o, 32'd127);
    chk("R6 set", {31'd0, sticky_o}, 32'd1);
    apply(mk(4'hE, 5'd7, 4'h1, 5'd0, 1'b0, 4'h2), -32'sd1000, 1'b1, 1'b0, 1'b0);
    chk("R4 low", result_o, 32'hFFFF_FF80);
    apply(mk(4'hE, 5'd7, 4'h1, 5'd0, 1'b0, 4'h2), -32'sd128, 1'b1, 1'b0, 1'b0);
    chk("R4 low bound pass", result_o, 32'hFFFF_FF80);
    chk("R6 no clamp keeps 0", {31'd0, sticky_o}, 32'd0);
    apply(mk(4'hE, 5'd7, 4'h1, 5'd0, 1'b0, 4'h2), 32'd128, 1'b1, 1'b0, 1'b0);
    chk("R4 just above", result_o, 32'd127);
    apply(mk(4'hE, 5'd0, 4'h1, 5'd0, 1'b0, 4'h2), 32'd5, 1'b1, 1'b0, 1'b0);
    chk("R4 n0 pos", result_o, 32'd0);
    apply(mk(4'hE, 5'd0, 4'h1, 5'd0, 1'b0, 4'h2), 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    chk("R4 n0 minus1", result_o, 32'hFFFF_FFFF);
    apply(mk(4'hE, 5'd0, 4'h1, 5'd0, 1'b0, 4'h2), -32'sd5, 1'b1, 1'b0, 1'b0);
    chk("R4 n0 neg", result_o, 32'hFFFF_FFFF);
    apply(mk(4'hE, 5'd31, 4'h1, 5'd0, 1'b0, 4'h2), 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    chk("R4 most negative n31", result_o, 32'h8000_0000);
    apply(mk(4'hE, 5'd30, 4'h1, 5'd0, 1'b0, 4'h2), 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    chk("R4 most negative n30", result_o, 32'hC000_0000);
  endtask

  task automatic t_unsigned;
    apply(mk(4'hE, 5'd8, 4'h1, 5'd0, 1'b0, 4'h2), 32'd300, 1'b0, 1'b0, 1'b0);
    chk("R5 high", result_o, 32'd255);
    apply(mk(4'hE, 5'd8, 4'h1, 5'd0, 1'b0, 4'h2), 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R5 neg", result_o, 32'd0);
    chk("R6 set unsigned", {31'd0, sticky_o}, 32'd1);
    apply(mk(4'hE, 5'd8, 4'h1, 5'd0, 1'b0, 4'h2), 32'd255, 1'b0, 1'b0, 1'b0);
    chk("R5 bound pass", result_o, 32'd255);
    apply(mk(4'hE, 5'd0, 4'h1, 5'd0, 1'b0, 4'h2), 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R5 n0", result_o, 32'd0);
    apply(mk(4'hE, 5'd31, 4'h1, 5'd0, 1'b0, 4'h2), 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R5 most positive", result_o, 32'h7FFF_FFFF);
    apply(mk(4'hE, 5'd31, 4'h1, 5'd0, 1'b0, 4'h2), 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    chk("R5 most negative", result_o, 32'd0);
  endtask

  task automatic t_sticky_cond;
    apply(mk(4'hE, 5'd31, 4'h1, 5'd0, 1'b0, 4'h2), 32'd1, 1'b1, 1'b0, 1'b1);
    chk("R6 never cleared", {31'd0, sticky_o}, 32'd1);
    apply(mk(4'h0, 5'd3, 4'h1, 5'd0, 1'b0, 4'h2), 32'd100, 1'b1, 1'b0, 1'b0);
    chk("R7 fail wr_en", {31'd0, wr_en_o}, 32'd0);
    chk("R7 fail sticky", {31'd0, sticky_o}, 32'd0);
    apply(mk(4'h0, 5'd3, 4'h1, 5'd0, 1'b0, 4'h2), 32'd100, 1'b1, 1'b1, 1'b0);
    chk("R7 pass wr_en", {31'd0, wr_en_o}, 32'd1);
    chk("R7 pass sticky", {31'd0, sticky_o}, 32'd1);
    chk("R7 pass result", result_o, 32'd7);
    apply(mk(4'hE, 5'd3, 4'h1, 5'd0, 1'b0, 4'h2), 32'd100, 1'b1, 1'b0, 1'b0);
    chk("R7 always wr_en", {31'd0, wr_en_o}, 32'd1);
  endtask

  task automatic t_sweep;
    int unsigned seed = 32'h1badf00d;
    logic [32:0] e;
    logic [31:0] v;
    for (int n = 0; n < 32; n++) begin
      for (int t = 0; t < 2; t++) begin
        for (int m = 0; m < 2; m++) begin
          for (int k = 0; k < 6; k++) begin
            logic [4:0] amt;
            seed = seed * 32'd1103515245 + 32'd12345;
            v = seed;
            if (k == 0) v = 32'h8000_0000;
            if (k == 1) v = 32'h7FFF_FFFF;
            if (k == 2) v = v >> (seed[31:27]);
            seed = seed * 32'd1103515245 + 32'd12345;
            amt = (k < 2) ? 5'd0 : seed[20:16];
            apply(mk(4'hE, 5'(n), 4'h3, amt, t[0], 4'h4), v, m[0], 1'b0, 1'b0);
            e = model(v, amt, t[0], 5'(n), m[0]);
            chk(m[0] ? "R4 sweep" : "R5 sweep", result_o, e[31:0]);
            chk("R6 sweep flag", {31'd0, sticky_o}, {31'd0, e[32]});
          end
        end
      end
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_idle;
    t_decode;
    t_lsl;
    t_asr;
    t_signed;
    t_unsigned;
    t_sticky_cond;
    t_sweep;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule